// File: doc/BRIEF.md
# Endian-Aware Coprocessor Load/Store Sequencer

This block sits between a 32-bit memory data bus and a coprocessor register file of sixteen 64-bit entries. It carries out the data phase of coprocessor load and store instructions. Address generation and bus arbitration happen elsewhere. For each instruction the sequencer raises a word request, then consumes or produces one bus word on every beat marked valid, and pulses a completion flag once the last word has moved.

There are four transfer kinds. The two 64-bit kinds, double-precision and 64-bit integer, take two bus words each. A runtime endianness input, captured when the instruction starts, decides whether the first word fills the upper half or the lower half. A single-precision float uses only the upper half of a register. A 32-bit integer is sign-extended into the whole register on a load and taken from the lower half on a store. The register file is internal, so a stored word always reflects the most recent loads.

Top module: `lsSeqTop`

## Requirements
- R1: A `start` pulse while idle captures the register index from instruction bits 15:12, together with the kind, the direction and the endianness. A `start` that arrives while a transfer is in progress has no effect on that transfer or on any register.
- R2: `wordReq` rises in the cycle after an accepted `start`. It stays high until the beat that carries the final word, and drops in the cycle after that beat.
- R3: A cycle without `beatValid` is ignored. It does not advance the word count, it writes nothing to the register file, and it keeps `wordReq` high.
- R4: The kinds double (`xferKind`=0) and 64-bit integer (`xferKind`=2) complete after exactly two valid beats.
- R5: With big-endian captured, the first word of a two-word transfer goes to or comes from the upper half, and the second word uses the lower half.
- R6: With little-endian captured, the first word of a two-word transfer uses the lower half, and the second word uses the upper half.
- R7: The float kind (`xferKind`=1) takes one beat. A float load writes the upper half and leaves the lower half unchanged. A float store outputs the upper half.
- R8: The 32-bit integer kind (`xferKind`=3) takes one beat. A load writes the word sign-extended to all 64 bits. A store outputs the lower half.
- R9: `done` is high for exactly one cycle, the cycle after the final valid beat.
- R10: After reset, `wordReq`, `done` and `wrData` are 0, and every register reads back as zero.
- R11: `wrData` is zero except while a store is requesting words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction (accepted only when idle) |
| instrWord | input | 32 | Instruction word; bits 15:12 select the register |
| xferKind | input | 2 | 0 double, 1 float, 2 64-bit int, 3 32-bit int |
| isStore | input | 1 | 1 store (register to bus), 0 load |
| bigEndian | input | 1 | Word order for two-word transfers, sampled at start |
| beatValid | input | 1 | Current bus word is valid / accepted |
| rdData | input | 32 | Bus word for loads |
| wrData | output | 32 | Bus word for stores |
| wordReq | output | 1 | Transfer in progress, words wanted |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check, on every cycle, that the completion pulse lasts one cycle and never overlaps a request. They also check that a request only rises after a start, that a request without a valid beat persists, and that the write bus stays zero while idle. Whether each word lands in the correct half, whether sign extension and float half-preservation are correct, whether the two endianness orders work, and whether a stray start mid-transfer is ignored can only be shown by the bench. It does this by loading known patterns and reading them back through stores.

// File: rtl/lsSeqPkg.sv
package lsSeqPkg;

  typedef enum logic [1:0] {
    KIND_DBL = 2'd0,
    KIND_FLT = 2'd1,
    KIND_I64 = 2'd2,
    KIND_I32 = 2'd3
  } xferKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic storeEn;    // store in progress: drive wrData
    logic readUpper;  // store word comes from the upper half
    logic loadUpper;  // write bus word into upper half
    logic loadLower;  // write bus word into lower half
    logic loadSext;   // write sign-extended word into whole register
  } lsStrobe_t;

  function automatic logic isWide(xferKind_e k);
    return (k == KIND_DBL) || (k == KIND_I64);
  endfunction

endpackage

// File: rtl/lsCtrl.sv
module lsCtrl
  import lsSeqPkg::*;
#(
  parameter int IDX_W      = 4,
  parameter int WIDE_BEATS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] regSel,
  input  logic [1:0]       kindIn,
  input  logic             isStore,
  input  logic             bigEndian,
  input  logic             beatValid,
  output logic             wordReq,
  output logic             done,
  output logic [IDX_W-1:0] regIdx,
  output lsStrobe_t        strb
);

  localparam int CNT_W = $clog2(WIDE_BEATS + 1);
  localparam logic [CNT_W-1:0] LAST_WIDE = CNT_W'(WIDE_BEATS - 1);

  logic             busyQ;
  logic [CNT_W-1:0] cntQ;
  xferKind_e        kindQ;
  logic             storeQ;
  logic             bigQ;
  logic [IDX_W-1:0] idxQ;
  logic             doneQ;

  logic             wide;
  logic [CNT_W-1:0] lastCnt;
  logic             lastBeat;
  logic             toUpper;
  logic             loadBeat;

  always_comb begin
    wide     = isWide(kindQ);
    lastCnt  = wide ? LAST_WIDE : '0;
    lastBeat = busyQ && beatValid && (cntQ == lastCnt);
    if (wide) begin
      toUpper = (cntQ == '0) ? bigQ : !bigQ;
    end else begin
      toUpper = (kindQ == KIND_FLT);
    end
    loadBeat       = busyQ && !storeQ && beatValid;
    strb.storeEn   = busyQ && storeQ;
    strb.readUpper = toUpper;
    strb.loadSext  = loadBeat && (kindQ == KIND_I32);
    strb.loadUpper = loadBeat && (kindQ != KIND_I32) && toUpper;
    strb.loadLower = loadBeat && (kindQ != KIND_I32) && !toUpper;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyQ  <= 1'b0;
      cntQ   <= '0;
      kindQ  <= KIND_DBL;
      storeQ <= 1'b0;
      bigQ   <= 1'b0;
      idxQ   <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= lastBeat;
      if (!busyQ) begin
        if (start) begin
          busyQ  <= 1'b1;
          cntQ   <= '0;
          kindQ  <= xferKind_e'(kindIn);
          storeQ <= isStore;
          bigQ   <= bigEndian;
          idxQ   <= regSel;
        end
      end else if (beatValid) begin
        if (lastBeat) begin
          busyQ <= 1'b0;
          cntQ  <= '0;
        end else begin
          cntQ <= cntQ + 1'b1;
        end
      end
    end
  end

  assign wordReq = busyQ;
  assign done    = doneQ;
  assign regIdx  = idxQ;

endmodule

// File: rtl/lsData.sv
module lsData
  import lsSeqPkg::*;
#(
  parameter int HALF_W   = 32,
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lsStrobe_t         strb,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic [HALF_W-1:0] rdData,
  output logic [HALF_W-1:0] wrData
);

  logic [HALF_W-1:0] regUpper [NUM_REGS];
  logic [HALF_W-1:0] regLower [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        regUpper[i] <= '0;
        regLower[i] <= '0;
      end
    end else begin
      if (strb.loadSext) begin
        regUpper[regIdx] <= {HALF_W{rdData[HALF_W-1]}};
        regLower[regIdx] <= rdData;
      end else begin
        if (strb.loadUpper) regUpper[regIdx] <= rdData;
        if (strb.loadLower) regLower[regIdx] <= rdData;
      end
    end
  end

  always_comb begin
    if (!strb.storeEn) begin
      wrData = '0;
    end else if (strb.readUpper) begin
      wrData = regUpper[regIdx];
    end else begin
      wrData = regLower[regIdx];
    end
  end

endmodule

// File: rtl/lsSeqTop.sv
module lsSeqTop
  import lsSeqPkg::*;
#(
  parameter int INSTR_W  = 32,
  parameter int HALF_W   = 32,
  parameter int NUM_REGS = 16,
  parameter int IDX_LSB  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [1:0]         xferKind,
  input  logic               isStore,
  input  logic               bigEndian,
  input  logic               beatValid,
  input  logic [HALF_W-1:0]  rdData,
  output logic [HALF_W-1:0]  wrData,
  output logic               wordReq,
  output logic               done
);

  localparam int IDX_W = $clog2(NUM_REGS);

  lsStrobe_t        strb;
  logic [IDX_W-1:0] regIdx;
  logic             unusedInstr;

  // only the register field of the instruction matters here
  assign unusedInstr = ^instrWord;

  lsCtrl #(
    .IDX_W      (IDX_W),
    .WIDE_BEATS (2)
  ) uCtrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .regSel    (instrWord[IDX_LSB +: IDX_W]),
    .kindIn    (xferKind),
    .isStore   (isStore),
    .bigEndian (bigEndian),
    .beatValid (beatValid),
    .wordReq   (wordReq),
    .done      (done),
    .regIdx    (regIdx),
    .strb      (strb)
  );

  lsData #(
    .HALF_W   (HALF_W),
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) uData (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb   (strb),
    .regIdx (regIdx),
    .rdData (rdData),
    .wrData (wrData)
  );

endmodule

// File: rtl/lsSeqChk.sv
module lsSeqChk #(
  parameter int HALF_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              beatValid,
  input logic              wordReq,
  input logic              done,
  input logic [HALF_W-1:0] wrData
);

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: completion follows a valid beat while requesting
  p_done_after_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wordReq && beatValid));

  // R2: request is low while completion is flagged
  p_done_excl_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wordReq);

  // R2: request only rises after a start
  p_req_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wordReq) |-> $past(start));

  // R3: a request without a valid beat persists
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wordReq && !beatValid) |=> wordReq);

  // R11: write bus quiet while idle
  p_wr_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wordReq |-> (wrData == '0));

endmodule

bind lsSeqTop lsSeqChk #(.HALF_W(HALF_W)) uChk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .beatValid (beatValid),
  .wordReq   (wordReq),
  .done      (done),
  .wrData    (wrData)
);

// File: tb/tb_lsSeqTop.sv
`timescale 1ns/1ps
module tb_lsSeqTop;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] instrWord;
  logic [1:0]  xferKind;
  logic        isStore;
  logic        bigEndian;
  logic        beatValid;
  logic [31:0] rdData;
  logic [31:0] wrData;
  logic        wordReq;
  logic        done;

  always #2 clk = ~clk;

  lsSeqTop dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instrWord(instrWord),
    .xferKind(xferKind), .isStore(isStore), .bigEndian(bigEndian),
    .beatValid(beatValid), .rdData(rdData), .wrData(wrData),
    .wordReq(wordReq), .done(done)
  );

  typedef struct packed {
    logic [3:0]  idx;
    logic [1:0]  kind;
    logic        big;
    logic [31:0] w0;
    logic [31:0] w1;
    logic [63:0] expReg;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{4'd3,  2'd0, 1'b1, 32'h11112222, 32'h33334444, 64'h11112222_33334444},
    '{4'd5,  2'd0, 1'b0, 32'hAAAA0001, 32'hBBBB0002, 64'hBBBB0002_AAAA0001},
    '{4'd3,  2'd1, 1'b1, 32'hCAFE0000, 32'h0,        64'hCAFE0000_33334444},
    '{4'd7,  2'd3, 1'b0, 32'h80000005, 32'h0,        64'hFFFFFFFF_80000005},
    '{4'd8,  2'd3, 1'b1, 32'h7FFFFFFF, 32'h0,        64'h00000000_7FFFFFFF},
    '{4'd15, 2'd2, 1'b1, 32'h01234567, 32'h89ABCDEF, 64'h01234567_89ABCDEF},
    '{4'd0,  2'd2, 1'b0, 32'hDEADBEEF, 32'h00C0FFEE, 64'h00C0FFEE_DEADBEEF},
    '{4'd7,  2'd1, 1'b0, 32'h12345678, 32'h0,        64'h12345678_80000005}
  };

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runXfer(input logic [1:0] kind, input bit store, input bit big,
                         input logic [3:0] idx, input logic [31:0] w0,
                         input logic [31:0] w1, input int gap,
                         output logic [31:0] o0, output logic [31:0] o1);
    int n;
    n  = (kind == 2'd0 || kind == 2'd2) ? 2 : 1;
    o0 = '0;
    o1 = '0;
    @(negedge clk);
    start = 1'b1; instrWord = {16'hA5C3, idx, 12'h96F};
    xferKind = kind; isStore = store; bigEndian = big;
    @(negedge clk);
    start = 1'b0; bigEndian = ~big; instrWord = 32'hFFFF_FFFF;
    chk("R2 request raised after start", 64'(wordReq), 64'd1);
    for (int b = 0; b < n; b++) begin
      for (int g = 0; g < gap; g++) begin
        beatValid = 1'b0; rdData = 32'hDEAD0BAD;
        @(negedge clk);
        chk("R3 request held without valid beat", 64'({wordReq, done}), 64'b10);
      end
      beatValid = 1'b1;
      rdData = (b == 0) ? w0 : w1;
      #1;
      if (b == 0) o0 = wrData; else o1 = wrData;
      @(negedge clk);
      beatValid = 1'b0; rdData = 32'h0BAD_F00D;
      if (b < n - 1)
        chk("R4 still requesting after first wide beat", 64'({wordReq, done}), 64'b10);
      else
        chk("R9 done after final beat, R2 request dropped", 64'({wordReq, done}), 64'b01);
    end
    @(negedge clk);
    chk("R9 done lasts one cycle", 64'(done), 64'd0);
  endtask

  task automatic readReg(input logic [3:0] idx, output logic [63:0] val);
    logic [31:0] a, b;
    runXfer(2'd0, 1'b1, 1'b1, idx, 32'h0, 32'h0, 0, a, b);
    val = {a, b};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] rv;
    logic [31:0] a, b;
    rst_n = 1'b0; start = 1'b0; instrWord = '0; xferKind = '0; isStore = 1'b0;
    bigEndian = 1'b0; beatValid = 1'b0; rdData = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset outputs", 64'({wordReq, done, wrData}), 64'd0);
    rst_n = 1'b1;
    readReg(4'd9, rv);
    chk("R10 register zero after reset", rv, 64'd0);

    // table walk: load then read back as a big-endian double
    for (int i = 0; i < NVEC; i++) begin
      runXfer(VECS[i].kind, 1'b0, VECS[i].big, VECS[i].idx,
              VECS[i].w0, VECS[i].w1, i % 3, a, b);
      readReg(VECS[i].idx, rv);
      $display("entry %0d readback %h", i, rv);
      chk("R4 R5 R6 R7 R8 load readback", rv, VECS[i].expReg);
    end

    // R6: little-endian store puts lower half first
    runXfer(2'd2, 1'b1, 1'b0, 4'd5, 32'h0, 32'h0, 1, a, b);
    chk("R6 little-endian store order", {a, b}, 64'hAAAA0001_BBBB0002);
    // R7: float store gives upper half
    runXfer(2'd1, 1'b1, 1'b0, 4'd3, 32'h0, 32'h0, 0, a, b);
    chk("R7 float store upper half", 64'(a), 64'hCAFE0000);
    // R8: int32 store gives lower half
    runXfer(2'd3, 1'b1, 1'b1, 4'd7, 32'h0, 32'h0, 2, a, b);
    chk("R8 int32 store lower half", 64'(a), 64'h80000005);

    // R1: start while busy is ignored; R11: wrData zero during a load
    @(negedge clk);
    start = 1'b1; instrWord = {16'h0, 4'd2, 12'hFFF}; xferKind = 2'd0;
    isStore = 1'b0; bigEndian = 1'b1;
    @(negedge clk);
    start = 1'b1; instrWord = {16'h0, 4'd4, 12'h0}; xferKind = 2'd3;
    isStore = 1'b0; bigEndian = 1'b0;
    beatValid = 1'b1; rdData = 32'h0000_1111;
    #1;
    chk("R11 wrData zero during load", 64'(wrData), 64'd0);
    @(negedge clk);
    start = 1'b0;
    chk("R1 second start ignored, still two beats", 64'({wordReq, done}), 64'b10);
    rdData = 32'h0000_2222;
    @(negedge clk);
    beatValid = 1'b0;
    chk("R1 R9 done after second beat", 64'({wordReq, done}), 64'b01);
    @(negedge clk);
    readReg(4'd2, rv);
    chk("R1 captured register index and big-endian", rv, 64'h00001111_00002222);
    readReg(4'd4, rv);
    chk("R1 ignored start wrote nothing", rv, 64'd0);
    chk("R11 wrData zero when idle", 64'(wrData), 64'd0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule